// File: doc/BRIEF.md
# Sixteen-Line GPIO Expander with Change Notification

This block gives a processor sixteen general-purpose lines behind a small register window, with registers every four bytes. A direction register picks which lines are outputs. A level register holds the state of every line. Software writes the level register through its own offset. Sixteen external line inputs can also set or clear single level bits. The block publishes the level masked by direction on `pin_out`. Each line has a one-cycle change strobe on `pin_chg`, so logic further along sees an edge without keeping its own history.

Publication is driven by a two-state machine. The idle state (`ST_IDLE`) holds the published value. A write to the direction register or to the level-write offset moves the machine to `ST_PUBLISH` on the next edge. While in that state it compares the masked level against the value last published. It replaces that value and strobes only the bits that differ. With no further publishing write it returns to `ST_IDLE`; another such write keeps it in `ST_PUBLISH`. Line-input events change the stored level only. They reach `pin_out` at the next direction or level write. Eight auxiliary registers below the direction register are storage only.

Top module: `gpx_expander`

## Requirements
- R1: After reset every register reads zero, `pin_out` is zero and `pin_chg` is zero.
- R2: The auxiliary registers at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C each read back the last value written to them, and writing them does not change `pin_out` or pulse `pin_chg`.
- R3: Offset 0x20 is the direction register (bit set = output line). It is readable. A write to it re-publishes the outputs.
- R4: A write to offset 0x24 stores the written data ANDed with the current direction into the level register. Offset 0x28 reads the raw level register.
- R5: A write to offset 0x20 or 0x24 on clock edge N makes `pin_out` equal to level AND direction, as held after edge N, from clock edge N+1 onward. Outside a publish cycle `pin_out` holds its value.
- R6: On a publish edge, `pin_chg` becomes the XOR of the new and old `pin_out` for one cycle, so bits with no change stay low. At every other time `pin_chg` is zero.
- R7: When `line_req[i]` is high on an edge, level bit i takes `line_val[i]`, whatever the direction. This is visible at 0x28 after that edge. `pin_out` does not change until the next 0x20 or 0x24 write.
- R8: On an edge where a 0x24 write and `line_req[i]` coincide, bit i takes `line_val[i]` and the other bits take the bus value.
- R9: Writes to 0x28, to offsets above 0x28, or to any offset whose two low bits are not zero change no register and publish nothing. Reads of 0x24, of those offsets and of misaligned offsets return zero.
- R10: Writes to 0x24 on consecutive edges each cause their own publish, one edge after each, with their own change strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| line_req | input | 16 | Per-line update request from external inputs |
| line_val | input | 16 | Per-line value applied where `line_req` is high |
| pin_out | output | 16 | Published level AND direction |
| pin_chg | output | 16 | One-cycle strobe on each published bit that changed |

## Verification
Several properties are checked on every cycle. The change strobe must always equal the XOR of the current and previous `pin_out`. It must be zero unless a publishing write came one edge earlier, and `pin_out` must stay put outside `ST_PUBLISH`. Line requests must land in the level register, a level write must be masked by direction, and ignored writes must leave direction and level untouched. The directed scenarios are what show actual values: auxiliary read-back, latency counted from the write, line events held back until a later write, priority of a line over a bus write on the same edge, and strobe patterns from back-to-back level writes.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PUBLISH = 1'b1
    } gpx_state_e;

endpackage

// File: rtl/gpx_regfile.sv
module gpx_regfile #(
    parameter int W     = 16,
    parameter int A     = 6,
    parameter int N_AUX = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [A-1:0] addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] line_req,
    input  logic [W-1:0] line_val,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] level_q,
    output logic         pub_req
);
    localparam int WW     = A - 2;
    localparam int AUX_IW = (N_AUX > 1) ? $clog2(N_AUX) : 1;
    localparam logic [WW-1:0] WORD_DIR = WW'(N_AUX);
    localparam logic [WW-1:0] WORD_LWR = WW'(N_AUX + 1);
    localparam logic [WW-1:0] WORD_LRD = WW'(N_AUX + 2);

    logic [WW-1:0] word;
    logic          aligned;
    logic          hit_aux, hit_dir, hit_lwr, hit_lrd;
    logic [W-1:0]  level_d;
    logic [W-1:0]  aux_q [N_AUX];

    assign word    = addr[A-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign hit_aux = aligned && (word < WORD_DIR);
    assign hit_dir = aligned && (word == WORD_DIR);
    assign hit_lwr = aligned && (word == WORD_LWR);
    assign hit_lrd = aligned && (word == WORD_LRD);
    assign pub_req = wr_en && (hit_dir || hit_lwr);

    generate
        for (genvar g = 0; g < N_AUX; g++) begin : g_aux
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    aux_q[g] <= '0;
                else if (wr_en && hit_aux && (word == WW'(g)))
                    aux_q[g] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && hit_dir)
            dir_q <= wdata;
    end

    // Bus write first, then per-line requests take priority bit by bit.
    always_comb begin
        level_d = level_q;
        if (wr_en && hit_lwr)
            level_d = wdata & dir_q;
        level_d = (level_d & ~line_req) | (line_val & line_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level_q <= '0;
        else
            level_q <= level_d;
    end

    always_comb begin
        rdata = '0;
        if (hit_aux)
            rdata = aux_q[word[AUX_IW-1:0]];
        else if (hit_dir)
            rdata = dir_q;
        else if (hit_lrd)
            rdata = level_q;
    end

    // R4
    p_level_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_lwr && line_req == '0) |=> (level_q == $past(wdata & dir_q)));

    // R7 and R8
    p_line_applied_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req != '0) |=> ((level_q & $past(line_req)) == $past(line_val & line_req)));

    // R9
    p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_dir && !hit_lwr && line_req == '0) |=> ($stable(level_q) && $stable(dir_q)));

endmodule

// File: rtl/gpx_publisher.sv
module gpx_publisher
    import gpx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pub_req,
    input  logic [W-1:0] level_q,
    input  logic [W-1:0] dir_q,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_chg
);
    gpx_state_e   state_q, state_d;
    logic [W-1:0] masked;

    assign masked = level_q & dir_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = pub_req ? ST_PUBLISH : ST_IDLE;
            ST_PUBLISH: state_d = pub_req ? ST_PUBLISH : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_out <= '0;
            pin_chg <= '0;
        end else begin
            unique case (state_q)
                ST_PUBLISH: begin
                    pin_out <= masked;
                    pin_chg <= masked ^ pin_out;
                end
                default: pin_chg <= '0;
            endcase
        end
    end

    // R6
    p_chg_is_delta_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_chg == (pin_out ^ $past(pin_out)));

    // R6
    p_chg_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pub_req, 2) |-> (pin_chg == '0));

    // R5 and R7
    p_out_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PUBLISH) |=> $stable(pin_out));

endmodule

// File: rtl/gpx_expander.sv
module gpx_expander #(
    parameter int W     = 16,
    parameter int A     = 6,
    parameter int N_AUX = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [A-1:0] bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] line_req,
    input  logic [W-1:0] line_val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_chg
);
    logic [W-1:0] dir_q;
    logic [W-1:0] level_q;
    logic         pub_req;

    gpx_regfile #(.W(W), .A(A), .N_AUX(N_AUX)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .line_req (line_req),
        .line_val (line_val),
        .rdata    (bus_rdata),
        .dir_q    (dir_q),
        .level_q  (level_q),
        .pub_req  (pub_req)
    );

    gpx_publisher #(.W(W)) i_pub (
        .clk     (clk),
        .rst_n   (rst_n),
        .pub_req (pub_req),
        .level_q (level_q),
        .dir_q   (dir_q),
        .pin_out (pin_out),
        .pin_chg (pin_chg)
    );

endmodule

// File: tb/test_gpx_expander.sv
module test_gpx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] line_req = '0;
    logic [15:0] line_val = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_chg;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpx_expander i_gpx_expander (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_req(line_req),
        .line_val(line_val), .pin_out(pin_out), .pin_chg(pin_chg)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives at a falling edge; returns at the next falling edge (write taken).
    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] r;
        chk("R1 pin_out", pin_out, 16'h0000);
        chk("R1 pin_chg", pin_chg, 16'h0000);
        bus_read(6'h20, r); chk("R1 dir", r, 16'h0000);
        bus_read(6'h28, r); chk("R1 level", r, 16'h0000);
        bus_read(6'h00, r); chk("R1 aux0", r, 16'h0000);
    endtask

    task automatic t_aux();
        logic [15:0] r;
        for (int i = 0; i < 8; i++) bus_write(6'(i * 4), 16'hA500 + 16'(i * 16'h111));
        @(negedge clk);
        chk("R2 no strobe", pin_chg, 16'h0000);
        chk("R2 pin_out", pin_out, 16'h0000);
        for (int i = 0; i < 8; i++) begin
            bus_read(6'(i * 4), r);
            chk("R2 aux readback", r, 16'hA500 + 16'(i * 16'h111));
        end
    endtask

    task automatic t_publish();
        logic [15:0] r;
        bus_write(6'h20, 16'h00FF);
        bus_read(6'h20, r); chk("R3 dir read", r, 16'h00FF);
        @(negedge clk);
        chk("R5 out after dir", pin_out, 16'h0000);
        bus_write(6'h24, 16'hFFFF);
        bus_read(6'h28, r); chk("R4 masked level", r, 16'h00FF);
        @(negedge clk);
        chk("R5 out", pin_out, 16'h00FF);
        chk("R6 strobe", pin_chg, 16'h00FF);
        @(negedge clk);
        chk("R6 one cycle", pin_chg, 16'h0000);
        bus_write(6'h20, 16'h0F0F);
        @(negedge clk);
        chk("R3 republish", pin_out, 16'h000F);
        chk("R3 strobe", pin_chg, 16'h00F0);
        bus_write(6'h24, 16'h0F0F);
        @(negedge clk);
        chk("R5 out2", pin_out, 16'h0F0F);
        chk("R6 strobe2", pin_chg, 16'h0F00);
        bus_write(6'h24, 16'h0F0F);
        @(negedge clk);
        chk("R6 no change no strobe", pin_chg, 16'h0000);
    endtask

    task automatic t_lines();
        logic [15:0] r;
        @(negedge clk);
        line_req = 16'hF000; line_val = 16'hA000;
        @(negedge clk);
        line_req = '0; line_val = '0;
        bus_read(6'h28, r); chk("R7 level from lines", r, 16'hAF0F);
        @(negedge clk);
        chk("R7 out held", pin_out, 16'h0F0F);
        chk("R7 no strobe", pin_chg, 16'h0000);
        bus_write(6'h20, 16'hFFFF);
        @(negedge clk);
        chk("R7 out later", pin_out, 16'hAF0F);
        chk("R7 strobe later", pin_chg, 16'hA000);
    endtask

    task automatic t_override();
        logic [15:0] r;
        @(negedge clk);
        bus_addr = 6'h24; bus_wdata = 16'h00FF; bus_wr = 1'b1;
        line_req = 16'h0003; line_val = 16'h0002;
        @(negedge clk);
        bus_wr = 1'b0; line_req = '0; line_val = '0;
        bus_read(6'h28, r); chk("R8 line wins", r, 16'h00FE);
        @(negedge clk);
        chk("R8 out", pin_out, 16'h00FE);
        chk("R8 strobe", pin_chg, 16'hAFF1);
    endtask

    task automatic t_ignored();
        logic [15:0] r;
        bus_write(6'h28, 16'h1234);
        bus_write(6'h2C, 16'h5555);
        bus_write(6'h22, 16'h7777);
        bus_write(6'h25, 16'h3333);
        bus_write(6'h3C, 16'h9999);
        @(negedge clk);
        chk("R9 no strobe", pin_chg, 16'h0000);
        bus_read(6'h28, r); chk("R9 level kept", r, 16'h00FE);
        bus_read(6'h20, r); chk("R9 dir kept", r, 16'hFFFF);
        bus_read(6'h24, r); chk("R9 read 0x24", r, 16'h0000);
        bus_read(6'h2C, r); chk("R9 read 0x2C", r, 16'h0000);
        bus_read(6'h22, r); chk("R9 read misaligned", r, 16'h0000);
        bus_read(6'h04, r); chk("R9 aux kept", r, 16'hA611);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        bus_addr = 6'h24; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 16'h0003;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 first out", pin_out, 16'h0001);
        chk("R10 first strobe", pin_chg, 16'h00FF);
        @(negedge clk);
        chk("R10 second out", pin_out, 16'h0003);
        chk("R10 second strobe", pin_chg, 16'h0002);
        @(negedge clk);
        chk("R10 strobe ends", pin_chg, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aux();
        t_publish();
        t_lines();
        t_override();
        t_ignored();
        t_back_to_back();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule